// File: doc/BRIEF.md
# Processor Reset Stretcher and Bus-Ready Synchronizer

This block turns an active-low reset request into an active-high processor reset and turns a set of bus-ready indications into one synchronized ready output. The reset output is registered on the falling edge of the processor clock. It goes high while the request is low. After the request is released it stays high for a fixed number of further falling edges. If a clock restart is still in progress when the request is released, the count waits for that restart to finish. A restart on its own never raises the reset.

Each bus-ready input counts only while its own active-low enable is low. The qualified inputs are ORed together. A strap input sets the synchronizer depth. Strap low selects two stages: a rising-edge register followed by a falling-edge register. Strap high selects a single falling-edge register. The ready path carries no reset, so it works while the processor is held in reset.

Top module: `rst_rdy_sync`

## Requirements
- R1: On a falling clock edge where `rst_req_n` is 0, `reset_out` becomes 1.
- R2: Once `rst_req_n` is 1 and `restart_done` is 1, `reset_out` stays 1 for exactly 16 further falling edges (STRETCH_LEN) and then falls to 0.
- R3: While `reset_out` is 1, each falling edge that sees `restart_done` at 0 reloads the stretch. The 16-edge count starts only after `restart_done` returns to 1.
- R4: While `reset_out` is 0 and `rst_req_n` is 1, `restart_done` has no effect: `reset_out` stays 0.
- R5: Bus-ready input `rdy[i]` contributes to the ready source only while `aen_n[i]` is 0. The source is the OR of all qualified inputs (bit 0 is bus 1, bit 1 is bus 2).
- R6: With `one_stage` at 0, `ready_out` takes, on each falling edge, the qualified source value sampled at the preceding rising edge.
- R7: With `one_stage` at 1, `ready_out` takes the qualified source value present at that falling edge.
- R8: A `rst_req_n` low pulse during a stretch in progress restarts the full 16-edge count from the release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor clock; outputs update on its falling edge |
| rst_req_n | input | 1 | Active-low reset request |
| restart_done | input | 1 | 1 when no clock/oscillator restart count is in progress |
| rdy | input | N_BUS | Bus-ready indications, active high |
| aen_n | input | N_BUS | Active-low enables, one per bus-ready input |
| one_stage | input | 1 | Strap: 1 gives one sync stage, 0 gives two |
| reset_out | output | 1 | Active-high processor reset |
| ready_out | output | 1 | Synchronized ready, active high |

## Verification
A wrong stretch counter shows up only as the falling edge of `reset_out` moving in time. A reload that is missed, or one counted off by one, makes the reset fall one or more falling edges early or late. This is visible no more than 17 falling edges after the last hold condition. A wrong or skipped first ready stage shows as `ready_out` out of step with the qualified source by half a clock at the next falling edge. A wrong enable polarity corrupts `ready_out` on the first falling edge that sees the bad qualification. The bench compares both outputs against a behavioural model after every falling edge, so each such fault is caught in the cycle where it first appears.

// File: rtl/rrs_pkg.sv
package rrs_pkg;

  typedef enum logic {
    SYNC_TWO = 1'b0,
    SYNC_ONE = 1'b1
  } sync_mode_e;

  // Select the value loaded into the output ready register.
  function automatic logic pick_ready(input sync_mode_e mode,
                                      input logic staged,
                                      input logic direct);
    return (mode == SYNC_ONE) ? direct : staged;
  endfunction

  // Hold condition for the reset stretch while reset is active.
  function automatic logic stretch_hold(input logic req_low,
                                        input logic restarting);
    return req_low | restarting;
  endfunction

endpackage

// File: rtl/rrs_ready_qual.sv
module rrs_ready_qual #(
  parameter int N_BUS = 2
) (
  input  logic [N_BUS-1:0] rdy,
  input  logic [N_BUS-1:0] aen_n,
  output logic             src
);
  logic [N_BUS-1:0] granted;

  for (genvar g = 0; g < N_BUS; g++) begin : g_bus
    assign granted[g] = rdy[g] & ~aen_n[g];
  end

  assign src = |granted;
endmodule

// File: rtl/rrs_ready_sync.sv
module rrs_ready_sync
  import rrs_pkg::*;
(
  input  logic clk,
  input  logic src,
  input  logic one_stage,
  output logic stage1,
  output logic ready
);
  sync_mode_e mode;
  logic       s1_q = 1'b0;
  logic       rdy_q = 1'b0;

  assign mode = sync_mode_e'(one_stage);

  always_ff @(posedge clk) begin
    s1_q <= src;
  end

  always_ff @(negedge clk) begin
    rdy_q <= pick_ready(mode, s1_q, src);
  end

  assign stage1 = s1_q;
  assign ready  = rdy_q;
endmodule

// File: rtl/rrs_reset_stretch.sv
module rrs_reset_stretch
  import rrs_pkg::*;
#(
  parameter int STRETCH_LEN = 16,
  localparam int CNT_W = $clog2(STRETCH_LEN + 1)
) (
  input  logic clk,
  input  logic rst_req_n,
  input  logic restart_done,
  output logic hold,
  output logic reset
);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(STRETCH_LEN);

  logic [CNT_W-1:0] cnt_q = '0;
  logic             rst_q = 1'b0;
  logic             pending;

  assign hold    = ~rst_req_n | (rst_q & stretch_hold(1'b0, ~restart_done));
  assign pending = (cnt_q != '0);

  always_ff @(negedge clk) begin
    if (!rst_req_n) begin
      rst_q <= 1'b1;
      cnt_q <= LOAD;
    end else if (rst_q) begin
      if (!restart_done) begin
        cnt_q <= LOAD;
      end else if (pending) begin
        cnt_q <= cnt_q - 1'b1;
      end
      rst_q <= stretch_hold(1'b0, ~restart_done) | pending;
    end
  end

  assign reset = rst_q;
endmodule

// File: rtl/rst_rdy_sync.sv
module rst_rdy_sync #(
  parameter int STRETCH_LEN = 16,
  parameter int N_BUS       = 2
) (
  input  logic             clk,
  input  logic             rst_req_n,
  input  logic             restart_done,
  input  logic [N_BUS-1:0] rdy,
  input  logic [N_BUS-1:0] aen_n,
  input  logic             one_stage,
  output logic             reset_out,
  output logic             ready_out
);
  logic qual_src;
  logic stage1;
  logic stretch_hold_w;

  rrs_reset_stretch #(.STRETCH_LEN(STRETCH_LEN)) i_stretch (
    .clk          (clk),
    .rst_req_n    (rst_req_n),
    .restart_done (restart_done),
    .hold         (stretch_hold_w),
    .reset        (reset_out)
  );

  rrs_ready_qual #(.N_BUS(N_BUS)) i_qual (
    .rdy   (rdy),
    .aen_n (aen_n),
    .src   (qual_src)
  );

  rrs_ready_sync i_sync (
    .clk       (clk),
    .src       (qual_src),
    .one_stage (one_stage),
    .stage1    (stage1),
    .ready     (ready_out)
  );
endmodule

// File: rtl/rst_rdy_sync_chk.sv
module rst_rdy_sync_chk #(
  parameter int STRETCH_LEN = 16
) (
  input logic clk,
  input logic rst_req_n,
  input logic restart_done,
  input logic one_stage,
  input logic qual_src,
  input logic stage1,
  input logic reset_out,
  input logic ready_out
);
  logic primed = 1'b0;
  int   since_hold = 0;

  always_ff @(negedge clk) begin
    primed <= 1'b1;
    if (!rst_req_n || (reset_out && !restart_done)) since_hold <= 0;
    else if (since_hold < STRETCH_LEN + 8) since_hold <= since_hold + 1;
  end

  p_assert_on_req_r1: assert property (@(negedge clk) disable iff (!primed)
    !rst_req_n |=> reset_out);

  p_min_stretch_r2: assert property (@(negedge clk) disable iff (!primed)
    $fell(reset_out) |-> since_hold == STRETCH_LEN + 1);

  p_restart_holds_r3: assert property (@(negedge clk) disable iff (!primed)
    (reset_out && !restart_done) |=> reset_out);

  p_restart_ignored_r4: assert property (@(negedge clk) disable iff (!primed)
    (!reset_out && rst_req_n) |=> !reset_out);

  p_two_stage_r6: assert property (@(negedge clk) disable iff (!primed)
    !one_stage |=> ready_out == $past(stage1));

  p_one_stage_r7: assert property (@(negedge clk) disable iff (!primed)
    one_stage |=> ready_out == $past(qual_src));
endmodule

bind rst_rdy_sync rst_rdy_sync_chk #(.STRETCH_LEN(STRETCH_LEN)) i_chk (
  .clk          (clk),
  .rst_req_n    (rst_req_n),
  .restart_done (restart_done),
  .one_stage    (one_stage),
  .qual_src     (qual_src),
  .stage1       (stage1),
  .reset_out    (reset_out),
  .ready_out    (ready_out)
);

// File: tb/test_rst_rdy_sync.sv
`timescale 1ns/1ps
module test_rst_rdy_sync;
  logic       clk = 1'b0;
  logic       rst_req_n = 1'b0;
  logic       restart_done = 1'b1;
  logic [1:0] rdy = 2'b00;
  logic [1:0] aen_n = 2'b11;
  logic       one_stage = 1'b0;
  logic       reset_out, ready_out;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  // behavioural model state
  bit exp_rst = 0;
  int remain = 0;
  bit exp_rdy = 0;
  bit mdl_s1 = 0;

  always #2.5 clk = ~clk;

  rst_rdy_sync i_rst_rdy_sync (
    .clk(clk), .rst_req_n(rst_req_n), .restart_done(restart_done),
    .rdy(rdy), .aen_n(aen_n), .one_stage(one_stage),
    .reset_out(reset_out), .ready_out(ready_out)
  );

  function automatic bit src_of(input logic [1:0] r, input logic [1:0] e);
    bit any = 0;
    for (int i = 0; i < 2; i++) if (r[i] === 1'b1 && e[i] === 1'b0) any = 1;
    return any;
  endfunction

  task automatic check(input string tag, input string what, input bit act, input bit exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic step(input string tag, input bit rn, input bit dn,
                      input logic [1:0] r, input logic [1:0] e, input bit one);
    @(posedge clk);
    mdl_s1 = src_of(rdy, aen_n);
    #1;
    rst_req_n = rn; restart_done = dn; rdy = r; aen_n = e; one_stage = one;
    @(negedge clk);
    if (!rst_req_n) begin
      exp_rst = 1; remain = 16;
    end else if (exp_rst) begin
      if (!restart_done) remain = 16;
      else if (remain > 0) remain--;
      else exp_rst = 0;
    end
    exp_rdy = one_stage ? src_of(rdy, aen_n) : mdl_s1;
    #1;
    check(tag, "reset_out", reset_out, exp_rst);
    check(tag, "ready_out", ready_out, exp_rdy);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired (all requirements)");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int highs;
    // R1: request held low
    for (int i = 0; i < 4; i++) step("R1", 0, 1, 2'b00, 2'b11, 0);
    // R2: release, count the stretch
    highs = 0;
    for (int i = 0; i < 22; i++) begin
      step("R2", 1, 1, 2'b00, 2'b11, 0);
      if (reset_out) highs++;
    end
    check("R2", "stretch length 16", highs == 16, 1'b1);
    // R4: restart flag toggles with reset inactive
    for (int i = 0; i < 6; i++) step("R4", 1, i[0], 2'b00, 2'b11, 0);
    check("R4", "reset stays low", reset_out, 1'b0);
    // R3: restart in progress across the release
    for (int i = 0; i < 3; i++) step("R3", 0, 0, 2'b00, 2'b11, 0);
    for (int i = 0; i < 10; i++) step("R3", 1, 0, 2'b00, 2'b11, 0);
    check("R3", "held during restart", reset_out, 1'b1);
    highs = 0;
    for (int i = 0; i < 22; i++) begin
      step("R3", 1, 1, 2'b00, 2'b11, 0);
      if (reset_out) highs++;
    end
    check("R3", "16 after restart end", highs == 16, 1'b1);
    // R8: request pulse mid-stretch restarts the count
    step("R8", 0, 1, 2'b00, 2'b11, 0);
    for (int i = 0; i < 8; i++) step("R8", 1, 1, 2'b00, 2'b11, 0);
    step("R8", 0, 1, 2'b00, 2'b11, 0);
    highs = 0;
    for (int i = 0; i < 22; i++) begin
      step("R8", 1, 1, 2'b00, 2'b11, 0);
      if (reset_out) highs++;
    end
    check("R8", "full 16 after repulse", highs == 16, 1'b1);
    // R5: all qualification combinations, single stage
    for (int i = 0; i < 16; i++) step("R5", 1, 1, 2'(i), 2'(i >> 2), 1);
    for (int i = 0; i < 16; i++) step("R5", 1, 1, 2'(i >> 2), 2'(i), 1);
    // R6: two-stage, toggling source
    for (int i = 0; i < 24; i++) step("R6", 1, 1, {1'b0, i[0] ^ i[2]}, 2'b10, 0);
    for (int i = 0; i < 12; i++) step("R6", 1, 1, {i[1], 1'b0}, 2'b01, 0);
    // R7: one-stage, toggling source, during reset too
    for (int i = 0; i < 12; i++) step("R7", i > 3, 1, {i[0], 1'b0}, 2'b00, 1);
    for (int i = 0; i < 12; i++) step("R7", 1, 1, {1'b0, i[1]}, 2'b00, i[2]);
    finished = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule